// File: doc/BRIEF.md
# Atomic Read-Modify-Write Shared Memory

This block is a small word-addressed memory that several requesters share through a single arbitrated port. Each requester presents an operation code, a word address, an operand and a comparison value, and it holds its valid signal until the block grants it. Plain loads and stores are supported. The block also performs synchronization primitives on one word: test-and-set, swap, compare-and-swap and fetch-and-add. Every operation, plain or atomic, runs as one indivisible read, compute and write-back sequence. The arbiter grants nobody else until the write-back cycle is over, so no other request can slip between the read and the write.

Each accepted request gets one response on a shared return bus. The response carries the word as it was before the operation, together with a flag that reports whether a compare-and-swap wrote. Software builds spin locks on test-and-set: a returned 0 means the caller now holds the lock, and a plain store of 0 releases it. A signed fetch-and-add operand of -1 gives an atomic decrement, which suits counting barriers. A parameter selects between a rotating-priority arbiter and a fixed-priority arbiter in which the lowest index wins.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every word reads as zero, no response is valid, and no requester is granted while none is requesting.
- R2: A load (code 000) returns the addressed word and leaves memory unchanged.
- R3: A store (code 001) writes the operand into the addressed word and returns the value the word held before.
- R4: Test-and-set (code 010) writes 1 into the word and returns the previous value. A returned 0 means the lock was acquired, and a plain store of 0 releases the lock.
- R5: Swap (code 011) writes the supplied operand, which may be any value, and returns the previous contents.
- R6: Compare-and-swap (code 100) writes the operand when the current word equals the comparison value, and it returns the old word with the success flag at 1. The success flag is 0 for every other operation.
- R7: Compare-and-swap with a mismatching comparison value leaves the word unchanged and returns the old word with the success flag at 0.
- R8: Fetch-and-add (code 101) adds the operand as a signed value modulo 2^32 and returns the pre-add value. An operand of -1 decrements the word.
- R9: At most one requester is granted in a cycle, only a requester with valid high is granted, and no grant is given in the cycle after an acceptance.
- R10: The response for a request accepted at a clock edge is valid, one-hot to that requester, during the second cycle after that edge. No response is valid at any other time.
- R11: With the rotating arbiter (the default) and all requesters continuously requesting, successive grants go to index (previous + 1) mod NUM_REQ.
- R12: The undefined codes 110 and 111 behave as loads. They return the word and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_REQ | Request valid, one bit per requester |
| req_op | input | 3*NUM_REQ | Operation code per requester (requester i at bits [3i+2:3i]) |
| req_addr | input | ADDR_W*NUM_REQ | Word address per requester |
| req_wdata | input | DATA_W*NUM_REQ | Store, swap or new value, or the signed addend |
| req_cmp | input | DATA_W*NUM_REQ | Comparison value for compare-and-swap |
| req_ready | output | NUM_REQ | Grant; the request is accepted at the edge where valid and ready are both high |
| rsp_valid | output | NUM_REQ | One-hot response strobe for the owning requester |
| rsp_rdata | output | DATA_W | Word value before the operation |
| rsp_cas_ok | output | 1 | Compare-and-swap wrote |

## Verification
The bound checker checks the handshake rules on every cycle: grants are one-hot and only go to valid requesters, the busy cycle after each acceptance has no grant, responses are one-hot and arrive exactly two edges after acceptance, and the success flag is never raised without a response. The data results can only be shown by the bench's scenarios against its reference model. These include lock acquire, contention and release; swap of arbitrary values; compare-and-swap hits and misses; decrement and wrap-around of fetch-and-add; undefined codes; four requesters adding to one word at once; and grant rotation under full load.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        AMO_LOAD  = 3'b000,
        AMO_STORE = 3'b001,
        AMO_TAS   = 3'b010,
        AMO_SWAP  = 3'b011,
        AMO_CAS   = 3'b100,
        AMO_FADD  = 3'b101
    } amo_op_e;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_EXEC
    } seq_state_e;

    // Control flags derived from an operation code
    typedef struct packed {
        logic writes;
        logic conditional;
        logic take_sum;
        logic take_one;
    } amo_ctl_t;

    function automatic amo_ctl_t amo_decode(input logic [OP_W-1:0] code);
        amo_ctl_t c;
        c = '0;
        case (code)
            AMO_STORE, AMO_SWAP: c.writes = 1'b1;
            AMO_TAS: begin
                c.writes   = 1'b1;
                c.take_one = 1'b1;
            end
            AMO_CAS: begin
                c.writes      = 1'b1;
                c.conditional = 1'b1;
            end
            AMO_FADD: begin
                c.writes   = 1'b1;
                c.take_sum = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/amo_arbiter.sv
module amo_arbiter #(
    parameter int N           = 4,
    parameter bit ROUND_ROBIN = 1'b1,
    localparam int IW         = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx
);

    generate
        if (ROUND_ROBIN) begin : g_rotate
            logic [IW-1:0] ptr_q;

            always_comb begin
                logic found;
                int   cand;
                found     = 1'b0;
                grant     = '0;
                grant_idx = '0;
                for (int k = 0; k < N; k++) begin
                    cand = (int'(ptr_q) + k) % N;
                    if (!found && req[cand]) begin
                        found       = 1'b1;
                        grant[cand] = 1'b1;
                        grant_idx   = IW'(cand);
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    ptr_q <= '0;
                end else if (advance) begin
                    if (grant_idx == IW'(N - 1)) begin
                        ptr_q <= '0;
                    end else begin
                        ptr_q <= grant_idx + IW'(1);
                    end
                end
            end
        end else begin : g_fixed
            always_comb begin
                logic found;
                found     = 1'b0;
                grant     = '0;
                grant_idx = '0;
                for (int k = 0; k < N; k++) begin
                    if (!found && req[k]) begin
                        found     = 1'b1;
                        grant[k]  = 1'b1;
                        grant_idx = IW'(k);
                    end
                end
            end

            logic unused_fixed;
            assign unused_fixed = ^{clk, rst, advance};
        end
    endgenerate

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [DW-1:0]   old_word,
    input  logic [DW-1:0]   operand,
    input  logic [DW-1:0]   expect_word,
    output logic [DW-1:0]   new_word,
    output logic            do_write,
    output logic            cas_hit
);

    amo_ctl_t ctl;
    logic     match;

    always_comb begin
        ctl     = amo_decode(op);
        match   = (old_word == expect_word);
        cas_hit = ctl.conditional && match;
        do_write = ctl.writes && (!ctl.conditional || match);
        if (ctl.take_one) begin
            new_word = DW'(1);
        end else if (ctl.take_sum) begin
            new_word = old_word + operand;
        end else begin
            new_word = operand;
        end
    end

endmodule

// File: rtl/amo_store.sv
module amo_store #(
    parameter int DW    = 32,
    parameter int AW    = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data
);

    logic [DW-1:0] words_q [DEPTH];

    generate
        for (genvar w = 0; w < DEPTH; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    words_q[w] <= '0;
                end else if (wr_en && addr == AW'(w)) begin
                    words_q[w] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_data = words_q[addr];

endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
    import amo_pkg::*;
#(
    parameter int NUM_REQ     = 4,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter bit ROUND_ROBIN = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_REQ-1:0]          req_valid,
    input  logic [OP_W*NUM_REQ-1:0]     req_op,
    input  logic [ADDR_W*NUM_REQ-1:0]   req_addr,
    input  logic [DATA_W*NUM_REQ-1:0]   req_wdata,
    input  logic [DATA_W*NUM_REQ-1:0]   req_cmp,
    output logic [NUM_REQ-1:0]          req_ready,
    output logic [NUM_REQ-1:0]          rsp_valid,
    output logic [DATA_W-1:0]           rsp_rdata,
    output logic                        rsp_cas_ok
);

    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    seq_state_e           state_q;
    logic [NUM_REQ-1:0]   grant;
    logic [IDX_W-1:0]     grant_idx;
    logic                 accept;

    logic [IDX_W-1:0]     own_q;
    logic [OP_W-1:0]      op_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    operand_q;
    logic [DATA_W-1:0]    expect_q;

    logic [DATA_W-1:0]    old_word;
    logic [DATA_W-1:0]    new_word;
    logic                 do_write;
    logic                 cas_hit;
    logic                 mem_we;

    amo_arbiter #(
        .N           (NUM_REQ),
        .ROUND_ROBIN (ROUND_ROBIN)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req_valid),
        .advance   (accept),
        .grant     (grant),
        .grant_idx (grant_idx)
    );

    // Grants only while idle: the exec cycle is the indivisible write-back
    assign req_ready = (state_q == SEQ_IDLE && !rst) ? grant : '0;
    assign accept    = |req_ready;

    amo_store #(
        .DW (DATA_W),
        .AW (ADDR_W)
    ) u_mem (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr_q),
        .rd_data (old_word),
        .wr_en   (mem_we),
        .wr_data (new_word)
    );

    amo_alu #(
        .DW (DATA_W)
    ) u_alu (
        .op          (op_q),
        .old_word    (old_word),
        .operand     (operand_q),
        .expect_word (expect_q),
        .new_word    (new_word),
        .do_write    (do_write),
        .cas_hit     (cas_hit)
    );

    assign mem_we = (state_q == SEQ_EXEC) && do_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            own_q      <= '0;
            op_q       <= '0;
            addr_q     <= '0;
            operand_q  <= '0;
            expect_q   <= '0;
            rsp_valid  <= '0;
            rsp_rdata  <= '0;
            rsp_cas_ok <= 1'b0;
        end else begin
            rsp_valid  <= '0;
            rsp_cas_ok <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        state_q   <= SEQ_EXEC;
                        own_q     <= grant_idx;
                        op_q      <= req_op[grant_idx*OP_W +: OP_W];
                        addr_q    <= req_addr[grant_idx*ADDR_W +: ADDR_W];
                        operand_q <= req_wdata[grant_idx*DATA_W +: DATA_W];
                        expect_q  <= req_cmp[grant_idx*DATA_W +: DATA_W];
                    end
                end
                SEQ_EXEC: begin
                    state_q    <= SEQ_IDLE;
                    rsp_valid  <= NUM_REQ'(1) << own_q;
                    rsp_rdata  <= old_word;
                    rsp_cas_ok <= cas_hit;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/amo_checker.sv
module amo_checker #(
    parameter int NUM_REQ = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] req_valid,
    input logic [NUM_REQ-1:0] req_ready,
    input logic [NUM_REQ-1:0] rsp_valid,
    input logic               rsp_cas_ok
);

    logic [NUM_REQ-1:0] acc;
    assign acc = req_valid & req_ready;

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));

    // R9
    grant_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready & ~req_valid) == '0);

    // R9
    busy_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (|acc) |=> (req_ready == '0));

    // R10
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_valid));

    // R10
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (|acc) |=> ##1 (rsp_valid == $past(acc, 2)));

    // R6
    cas_flag_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_cas_ok |-> (|rsp_valid));

endmodule

bind atomic_mem_unit amo_checker #(
    .NUM_REQ (NUM_REQ)
) u_amo_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_cas_ok (rsp_cas_ok)
);

// File: tb/atomic_mem_unit_test.sv
module atomic_mem_unit_test;

    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      req_valid = '0;
    logic [3*N-1:0]    req_op = '0;
    logic [AW*N-1:0]   req_addr = '0;
    logic [DW*N-1:0]   req_wdata = '0;
    logic [DW*N-1:0]   req_cmp = '0;
    logic [N-1:0]      req_ready;
    logic [N-1:0]      rsp_valid;
    logic [DW-1:0]     rsp_rdata;
    logic              rsp_cas_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    atomic_mem_unit uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_cmp    (req_cmp),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_cas_ok (rsp_cas_ok)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] %s: actual=%h expected=%h", tag, phase, what, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'b000: return "R2";
            3'b001: return "R3";
            3'b010: return "R4";
            3'b011: return "R5";
            3'b100: return "R6";
            3'b101: return "R8";
            default: return "R12";
        endcase
    endfunction

    // Behavioural reference model
    logic [DW-1:0] mem_m [DEPTH];
    bit            pend = 0;
    int            age = 0;
    int            p_idx;
    logic [2:0]    p_op;
    logic [DW-1:0] p_old;
    bit            p_ok;
    bit            rot_on = 0;
    int            rot_cnt = 0;
    int            rot_last = 0;

    initial for (int a = 0; a < DEPTH; a++) mem_m[a] = '0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [N-1:0] acc;
            if (pend && age == 1) begin
                chk(rsp_valid == N'(1 << p_idx), "R10", "response strobe",
                    DW'(rsp_valid), DW'(1 << p_idx));
                chk(rsp_rdata == p_old, op_tag(p_op), "old value", rsp_rdata, p_old);
                chk(rsp_cas_ok == p_ok, p_ok ? "R6" : (p_op == 3'b100 ? "R7" : "R6"),
                    "cas flag", DW'(rsp_cas_ok), DW'(p_ok));
                pend = 0;
            end else begin
                chk(rsp_valid == '0, "R10", "idle strobe", DW'(rsp_valid), '0);
                if (pend) begin
                    chk(req_ready == '0, "R9", "grant while busy", DW'(req_ready), '0);
                    age = 1;
                end
            end
            acc = req_valid & req_ready;
            if (acc != '0) begin
                int i;
                logic [AW-1:0] a;
                logic [DW-1:0] wd, cm;
                chk($countones(acc) == 1, "R9", "single grant", DW'(acc), '0);
                i = 0;
                for (int k = N - 1; k >= 0; k--) if (acc[k]) i = k;
                if (rot_on) begin
                    if (rot_cnt > 0)
                        chk(i == (rot_last + 1) % N, "R11", "rotation", DW'(i),
                            DW'((rot_last + 1) % N));
                    rot_cnt++;
                    rot_last = i;
                end
                p_idx = i;
                p_op  = req_op[i*3 +: 3];
                a     = req_addr[i*AW +: AW];
                wd    = req_wdata[i*DW +: DW];
                cm    = req_cmp[i*DW +: DW];
                p_old = mem_m[a];
                p_ok  = 0;
                case (p_op)
                    3'b001, 3'b011: mem_m[a] = wd;
                    3'b010: mem_m[a] = 1;
                    3'b100: if (p_old == cm) begin mem_m[a] = wd; p_ok = 1; end
                    3'b101: mem_m[a] = p_old + wd;
                    default: ;
                endcase
                pend = 1;
                age  = 0;
            end
        end
    end

    task automatic set_req(input int i, input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input logic [DW-1:0] cm);
        req_op[i*3 +: 3]     = op;
        req_addr[i*AW +: AW] = a;
        req_wdata[i*DW +: DW] = wd;
        req_cmp[i*DW +: DW]  = cm;
        req_valid[i]         = 1'b1;
    endtask

    task automatic wait_all();
        while (req_valid != '0) begin
            logic [N-1:0] hit;
            @(negedge clk);
            hit = req_valid & req_ready;
            @(posedge clk);
            #1;
            req_valid = req_valid & ~hit;
        end
    endtask

    task automatic issue(input int i, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic [DW-1:0] cm);
        @(posedge clk);
        #1;
        set_req(i, op, a, wd, cm);
        wait_all();
    endtask

    task automatic finish_run();
        repeat (4) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(rsp_valid == '0, "R1", "no response after reset", DW'(rsp_valid), '0);
        chk(req_ready == '0, "R1", "no grant without request", DW'(req_ready), '0);
        phase = "R1";
        for (int a = 0; a < DEPTH; a++) issue(a % N, 3'b000, AW'(a), '0, '0);

        phase = "store-load";
        issue(1, 3'b001, 4'd3, 32'h0000_0005, '0);           // R3
        issue(2, 3'b000, 4'd3, '0, '0);                       // R2
        issue(0, 3'b001, 4'd3, 32'hCAFE_0001, '0);           // R3 returns 5

        phase = "lock";
        issue(0, 3'b010, 4'd7, 32'h55, '0);                   // R4 acquire (0)
        issue(1, 3'b010, 4'd7, '0, '0);                       // R4 held (1)
        issue(0, 3'b001, 4'd7, '0, '0);                       // R4 release
        issue(1, 3'b010, 4'd7, '0, '0);                       // R4 acquire (0)

        phase = "swap";
        issue(2, 3'b011, 4'd2, 32'hDEAD_BEEF, '0);           // R5
        issue(3, 3'b011, 4'd2, 32'h1234_5678, '0);           // R5

        phase = "cas";
        issue(0, 3'b100, 4'd2, 32'h0000_000A, 32'h1234_5678); // R6 hit
        issue(1, 3'b100, 4'd2, 32'h0000_00FF, 32'h1234_5678); // R7 miss
        issue(2, 3'b000, 4'd2, '0, '0);                       // R7 unchanged

        phase = "fadd";
        issue(3, 3'b101, 4'd9, 32'd5, '0);                    // R8
        issue(3, 3'b101, 4'd9, 32'hFFFF_FFFF, '0);            // R8 decrement
        issue(0, 3'b011, 4'd9, 32'hFFFF_FFFF, '0);
        issue(0, 3'b101, 4'd9, 32'd1, '0);                    // R8 wrap to 0
        issue(0, 3'b000, 4'd9, '0, '0);

        phase = "undefined";
        issue(1, 3'b110, 4'd3, 32'h0BAD_0BAD, '0);            // R12
        issue(2, 3'b111, 4'd3, 32'h0BAD_0BAD, 32'hCAFE_0001); // R12
        issue(3, 3'b000, 4'd3, '0, '0);

        phase = "contention";
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) set_req(i, 3'b101, 4'd4, DW'(i + 1), '0);
        wait_all();
        issue(0, 3'b000, 4'd4, '0, '0);                       // R8 sum of 10

        phase = "rotation";
        @(posedge clk);
        #1;
        rot_cnt = 0;
        rot_on  = 1;
        for (int i = 0; i < N; i++) set_req(i, 3'b000, AW'(i), '0, '0);
        while (rot_cnt < 12) @(posedge clk);
        #1;
        req_valid = '0;
        rot_on = 0;

        phase = "random";
        for (int n = 0; n < 150; n++) begin
            logic [2:0]  op;
            logic [DW-1:0] cm;
            op = 3'($urandom_range(0, 7));
            cm = ($urandom_range(0, 1) == 1) ? 32'd1 : DW'($urandom_range(0, 3));
            issue($urandom_range(0, N - 1), op, AW'($urandom_range(0, 3)),
                  DW'($urandom_range(0, 3)), cm);
        end

        finish_run();
    end

endmodule